// File: doc/BRIEF.md
# Hub Server Router with ID-Tagged Requests and Per-Client Response Delivery

The block sits between a set of distributed clients and a single central server. Every client owns a request handshake (it offers a request and waits for ready) and a response handshake (the hub offers a response and waits for the client's ready). The server side mirrors this: it takes merged requests through one handshake and returns responses through another.

In the request direction the hub is a many-to-one merge. Pending client requests are chosen in round-robin order and placed in a single output register. The register carries the request payload together with the index of the client that issued it. In the response direction the server returns a payload plus that same index. The hub strips the index and writes the payload into a small FIFO owned by the named client. A client that stops taking responses therefore only fills its own FIFO. Responses carrying an index with no client behind it are consumed and discarded, and a sticky error flag records that this happened.

Typical use is a shared memory port, statistics engine or service unit that many modules call. Callers stay unaware of one another, and the server needs no knowledge of where the callers sit.

Top module: `hub_server_router`

## Requirements
- R1: Each request taken from client i appears at the server port with `srv_req_data` equal to the client's payload and `srv_req_id` equal to i (clients are numbered 0 to N_CLIENTS-1 by their bit position in the per-client vectors and their DW-wide slice in the flattened data buses).
- R2: When the request register can load (it is empty, or `srv_req_ready` is high), exactly one pending client sees `cli_req_ready` high. That client is the first one with `cli_req_valid` high when scanning upward from the last accepted client plus one, wrapping past N_CLIENTS-1 to 0. After reset the scan starts at client 0. When the register cannot load, every `cli_req_ready` is low.
- R3: While `srv_req_valid` is high and `srv_req_ready` is low, `srv_req_valid`, `srv_req_id` and `srv_req_data` hold their values on the next cycle.
- R4: A response accepted with `srv_rsp_id` = i < N_CLIENTS is delivered to client i only, with its payload unchanged. The ID is not forwarded.
- R5: Responses for a given client are delivered in the order the server returned them, and none is lost or duplicated.
- R6: Each client has a response FIFO of RSP_DEPTH entries. `cli_rsp_valid[i]` is high exactly when client i's FIFO holds at least one entry. For an in-range ID, `srv_rsp_ready` is low exactly when the named client's FIFO is full, so a full FIFO for one client never stalls responses addressed to another.
- R7: A response whose ID is N_CLIENTS or larger is accepted at once (`srv_rsp_ready` high) and dropped. `bad_id_err` goes high on the following cycle and stays high until reset.
- R8: During and immediately after synchronous reset, `srv_req_valid`, every `cli_rsp_valid` and `bad_id_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cli_req_valid | input | N_CLIENTS | Per-client request offered |
| cli_req_ready | output | N_CLIENTS | Per-client request taken this cycle |
| cli_req_data | input | N_CLIENTS*DW | Flattened request payloads, client i in bits [i*DW +: DW] |
| srv_req_valid | output | 1 | Merged request available to the server |
| srv_req_ready | input | 1 | Server takes the merged request |
| srv_req_data | output | DW | Merged request payload |
| srv_req_id | output | ID_W | Index of the client that issued the request |
| srv_rsp_valid | input | 1 | Server offers a response |
| srv_rsp_ready | output | 1 | Hub takes the response |
| srv_rsp_data | input | DW | Response payload |
| srv_rsp_id | input | ID_W | Index of the destination client |
| cli_rsp_valid | output | N_CLIENTS | Per-client response available |
| cli_rsp_ready | input | N_CLIENTS | Per-client response taken |
| cli_rsp_data | output | N_CLIENTS*DW | Flattened response payloads, client i in bits [i*DW +: DW] |
| bad_id_err | output | 1 | Sticky flag: a response with an out-of-range ID was dropped |

## Verification
Two functions can fall in the same cycle. A client FIFO can be written by a routed server response while the client pops its head, and that same full-or-not state decides `srv_rsp_ready`. The bench provokes the overlap with random client ready patterns against a server that returns responses after random latency. It also holds one client stalled for hundreds of cycles, so its FIFO sits full while responses for the other clients keep arriving. On every clock a behavioural model, holding occupancy counts and expected-payload queues, predicts `srv_rsp_ready` and each `cli_rsp_valid` after the push and pop of the previous edge. The bench also requires that responses to other clients were accepted while the stalled FIFO was full.

// File: rtl/hub_pkg.sv
package hub_pkg;

  // Width of an index able to address n items (at least one bit).
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/hub_rr_arbiter.sv
module hub_rr_arbiter #(
  parameter  int N  = 5,
  localparam int IW = hub_pkg::idx_w(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] grant_idx,
  output logic          any_req
);

  logic [IW-1:0] last_q;
  int            scan;
  logic          found;

  // Scan upward from the client after the last winner, wrapping once.
  always_comb begin
    grant     = '0;
    grant_idx = '0;
    found     = 1'b0;
    scan      = 0;
    for (int k = 1; k <= N; k++) begin
      scan = int'(last_q) + k;
      if (scan >= N) scan = scan - N;
      if (!found && req[scan[IW-1:0]]) begin
        found                = 1'b1;
        grant[scan[IW-1:0]]  = 1'b1;
        grant_idx            = scan[IW-1:0];
      end
    end
  end

  assign any_req = |req;

  always_ff @(posedge clk) begin
    if (rst)                     last_q <= IW'(N - 1);
    else if (advance && any_req) last_q <= grant_idx;
  end

endmodule

// File: rtl/hub_req_merge.sv
module hub_req_merge #(
  parameter  int N  = 5,
  parameter  int DW = 16,
  localparam int IW = hub_pkg::idx_w(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    cli_req_valid,
  output logic [N-1:0]    cli_req_ready,
  input  logic [N*DW-1:0] cli_req_data,
  output logic            srv_req_valid,
  input  logic            srv_req_ready,
  output logic [DW-1:0]   srv_req_data,
  output logic [IW-1:0]   srv_req_id
);

  logic          load;
  logic          any;
  logic [N-1:0]  grant;
  logic [IW-1:0] gidx;

  // The output register may take a new entry when empty or draining.
  assign load = !srv_req_valid || srv_req_ready;

  hub_rr_arbiter #(.N(N)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .req       (cli_req_valid),
    .advance   (load),
    .grant     (grant),
    .grant_idx (gidx),
    .any_req   (any)
  );

  assign cli_req_ready = grant & {N{load}};

  always_ff @(posedge clk) begin
    if (rst)       srv_req_valid <= 1'b0;
    else if (load) srv_req_valid <= any;
  end

  always_ff @(posedge clk) begin
    if (load && any) begin
      srv_req_data <= cli_req_data[int'(gidx)*DW +: DW];
      srv_req_id   <= gidx;
    end
  end

  // R3: a stalled request is held unchanged
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (srv_req_valid && !srv_req_ready) |=>
      (srv_req_valid && $stable(srv_req_data) && $stable(srv_req_id)));

  // R2: at most one client taken, and only one that asked
  a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cli_req_ready) && ((cli_req_ready & ~cli_req_valid) == '0));

  // R1: the tag on a merged request names an existing client
  a_r1_id_range: assert property (@(posedge clk) disable iff (rst)
    srv_req_valid |-> (int'(srv_req_id) < N));

endmodule

// File: rtl/hub_rsp_fifo.sv
module hub_rsp_fifo #(
  parameter  int DW    = 16,
  parameter  int DEPTH = 4,
  localparam int AW    = hub_pkg::idx_w(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= bump(wp);
      if (rd_en) rp <= bump(rp);
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R6: the router never writes a full queue
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && full));

  // R6: a client never pops an empty queue
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && empty));

endmodule

// File: rtl/hub_server_router.sv
module hub_server_router #(
  parameter  int N_CLIENTS = 5,
  parameter  int DW        = 16,
  parameter  int RSP_DEPTH = 4,
  localparam int ID_W      = hub_pkg::idx_w(N_CLIENTS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_CLIENTS-1:0]    cli_req_valid,
  output logic [N_CLIENTS-1:0]    cli_req_ready,
  input  logic [N_CLIENTS*DW-1:0] cli_req_data,
  output logic                    srv_req_valid,
  input  logic                    srv_req_ready,
  output logic [DW-1:0]           srv_req_data,
  output logic [ID_W-1:0]         srv_req_id,
  input  logic                    srv_rsp_valid,
  output logic                    srv_rsp_ready,
  input  logic [DW-1:0]           srv_rsp_data,
  input  logic [ID_W-1:0]         srv_rsp_id,
  output logic [N_CLIENTS-1:0]    cli_rsp_valid,
  input  logic [N_CLIENTS-1:0]    cli_rsp_ready,
  output logic [N_CLIENTS*DW-1:0] cli_rsp_data,
  output logic                    bad_id_err
);

  logic [N_CLIENTS-1:0] q_full, q_empty, q_wr, q_rd;
  logic                 id_ok;
  logic                 dest_full;

  // Request direction: tagged many-to-one merge.
  hub_req_merge #(.N(N_CLIENTS), .DW(DW)) u_merge (
    .clk           (clk),
    .rst           (rst),
    .cli_req_valid (cli_req_valid),
    .cli_req_ready (cli_req_ready),
    .cli_req_data  (cli_req_data),
    .srv_req_valid (srv_req_valid),
    .srv_req_ready (srv_req_ready),
    .srv_req_data  (srv_req_data),
    .srv_req_id    (srv_req_id)
  );

  // Response direction: strip the tag and steer into per-client queues.
  assign id_ok = int'(srv_rsp_id) < N_CLIENTS;

  always_comb begin
    dest_full = 1'b0;
    for (int i = 0; i < N_CLIENTS; i++) begin
      if (srv_rsp_id == ID_W'(i)) dest_full = q_full[i];
    end
  end

  assign srv_rsp_ready = !id_ok || !dest_full;

  for (genvar g = 0; g < N_CLIENTS; g++) begin : g_client
    assign q_wr[g]          = srv_rsp_valid && (srv_rsp_id == ID_W'(g)) && !q_full[g];
    assign q_rd[g]          = cli_rsp_valid[g] && cli_rsp_ready[g];
    assign cli_rsp_valid[g] = !q_empty[g];

    hub_rsp_fifo #(.DW(DW), .DEPTH(RSP_DEPTH)) u_q (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (q_wr[g]),
      .wr_data (srv_rsp_data),
      .full    (q_full[g]),
      .rd_en   (q_rd[g]),
      .rd_data (cli_rsp_data[g*DW +: DW]),
      .empty   (q_empty[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                          bad_id_err <= 1'b0;
    else if (srv_rsp_valid && !id_ok) bad_id_err <= 1'b1;
  end

  // R7: the error flag never clears outside reset
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    bad_id_err |=> bad_id_err);

  // R7: an unroutable response is always consumed and flagged
  a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
    (srv_rsp_valid && !id_ok) |-> (srv_rsp_ready ##1 bad_id_err));

  // R4: a routable response is written to at most one queue
  a_r4_one_dest: assert property (@(posedge clk) disable iff (rst)
    $onehot0(q_wr));

endmodule

// File: tb/hub_server_router_test.sv
module hub_server_router_test;
  localparam int NC    = 5;
  localparam int DW    = 16;
  localparam int DEPTH = 4;
  localparam int IW    = 3;
  localparam logic [DW-1:0] MASK = 16'h5A5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [NC-1:0]    cli_req_valid, cli_req_ready, cli_rsp_valid, cli_rsp_ready;
  logic [NC*DW-1:0] cli_req_data, cli_rsp_data;
  logic             srv_req_valid, srv_req_ready, srv_rsp_valid, srv_rsp_ready, bad_id_err;
  logic [DW-1:0]    srv_req_data, srv_rsp_data;
  logic [IW-1:0]    srv_req_id, srv_rsp_id;
  logic [DW-1:0]    cd [NC];

  always_comb
    for (int i = 0; i < NC; i++) cli_req_data[i*DW +: DW] = cd[i];

  hub_server_router #(.N_CLIENTS(NC), .DW(DW), .RSP_DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst),
    .cli_req_valid(cli_req_valid), .cli_req_ready(cli_req_ready), .cli_req_data(cli_req_data),
    .srv_req_valid(srv_req_valid), .srv_req_ready(srv_req_ready),
    .srv_req_data(srv_req_data), .srv_req_id(srv_req_id),
    .srv_rsp_valid(srv_rsp_valid), .srv_rsp_ready(srv_rsp_ready),
    .srv_rsp_data(srv_rsp_data), .srv_rsp_id(srv_rsp_id),
    .cli_rsp_valid(cli_rsp_valid), .cli_rsp_ready(cli_rsp_ready), .cli_rsp_data(cli_rsp_data),
    .bad_id_err(bad_id_err)
  );

  int vec = 0, bad = 0, cyc = 0, iso_hits = 0;
  int m_last, m_id;
  logic m_v, err_m;
  logic [DW-1:0] m_d;
  int occ [NC];
  int seq [NC];
  int delivered [NC];
  bit acc_req [NC];
  bit acc_srv;
  logic [DW-1:0] exp_q [NC][$];
  int            sq_id [$];
  logic [DW-1:0] sq_d [$];
  int            sq_t [$];
  bit req_en = 0, stall2 = 0, inject_bad = 0, all_ready = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic step();
    int w, idx;
    bit load, exp_r;
    logic [NC-1:0] exp_rdy;
    @(negedge clk);
    cyc++;
    // retire the handshakes of the previous edge
    for (int i = 0; i < NC; i++)
      if (acc_req[i]) begin cli_req_valid[i] = 1'b0; seq[i]++; acc_req[i] = 0; end
    if (acc_srv) begin
      void'(sq_id.pop_front()); void'(sq_d.pop_front()); void'(sq_t.pop_front());
      acc_srv = 0;
    end
    // drive new stimulus
    for (int i = 0; i < NC; i++)
      if (!cli_req_valid[i] && req_en && $urandom_range(2) == 0) begin
        cli_req_valid[i] = 1'b1;
        cd[i] = {3'(i), 13'(seq[i])};
      end
    srv_req_ready = ($urandom_range(3) != 0);
    if (inject_bad && $urandom_range(15) == 0) begin
      sq_id.push_back(NC + int'($urandom_range(2)));
      sq_d.push_back(16'($urandom));
      sq_t.push_back(cyc);
    end
    if (sq_id.size() > 0 && sq_t[0] <= cyc) begin
      srv_rsp_valid = 1'b1; srv_rsp_id = IW'(sq_id[0]); srv_rsp_data = sq_d[0];
    end else begin
      srv_rsp_valid = 1'b0; srv_rsp_id = '0; srv_rsp_data = '0;
    end
    for (int i = 0; i < NC; i++)
      cli_rsp_ready[i] = all_ready ? 1'b1 : (stall2 && i == 2) ? 1'b0 : ($urandom_range(3) != 0);
    #1;
    // registered outputs against the model
    check(srv_req_valid === m_v, "R3", "srv_req_valid", srv_req_valid, m_v);
    if (m_v) begin
      check(int'(srv_req_id) == m_id, "R1", "srv_req_id", srv_req_id, m_id);
      check(srv_req_data === m_d, "R1", "srv_req_data", srv_req_data, m_d);
    end
    check(bad_id_err === err_m, "R7", "bad_id_err", bad_id_err, err_m);
    for (int i = 0; i < NC; i++)
      check(cli_rsp_valid[i] === (occ[i] > 0), "R6", $sformatf("cli_rsp_valid[%0d]", i),
            cli_rsp_valid[i], occ[i] > 0);
    // round-robin pick
    load = !m_v || srv_req_ready;
    w = -1;
    for (int k = 1; k <= NC; k++) begin
      idx = (m_last + k) % NC;
      if (w < 0 && cli_req_valid[idx]) w = idx;
    end
    exp_rdy = '0;
    if (load && w >= 0) exp_rdy[w] = 1'b1;
    check(cli_req_ready === exp_rdy, "R2", "cli_req_ready", cli_req_ready, exp_rdy);
    // behavioural server takes a request
    if (m_v && srv_req_ready) begin
      sq_id.push_back(m_id);
      sq_d.push_back(m_d ^ MASK);
      sq_t.push_back(cyc + 1 + int'($urandom_range(5)));
      exp_q[m_id].push_back(m_d ^ MASK);
    end
    if (load) begin
      m_v = (w >= 0);
      if (w >= 0) begin m_id = w; m_d = cd[w]; m_last = w; acc_req[w] = 1; end
    end
    // server response acceptance, judged before this edge's pops
    exp_r = 0;
    if (srv_rsp_valid) begin
      exp_r = (sq_id[0] >= NC) ? 1'b1 : (occ[sq_id[0]] < DEPTH);
      check(srv_rsp_ready === exp_r, "R6", "srv_rsp_ready", srv_rsp_ready, exp_r);
    end
    // client deliveries
    for (int i = 0; i < NC; i++)
      if (occ[i] > 0 && cli_rsp_ready[i]) begin
        check(cli_rsp_data[i*DW +: DW] === exp_q[i][0], "R4", $sformatf("cli_rsp_data[%0d] (R5 order)", i),
              cli_rsp_data[i*DW +: DW], exp_q[i][0]);
        void'(exp_q[i].pop_front());
        occ[i]--;
        delivered[i]++;
      end
    if (srv_rsp_valid && exp_r) begin
      acc_srv = 1;
      if (sq_id[0] >= NC) err_m = 1'b1;
      else begin
        if (stall2 && sq_id[0] != 2 && occ[2] == DEPTH) iso_hits++;
        occ[sq_id[0]]++;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    bit drained;
    cli_req_valid = '0; cli_rsp_ready = '0; srv_req_ready = 1'b0;
    srv_rsp_valid = 1'b0; srv_rsp_id = '0; srv_rsp_data = '0;
    for (int i = 0; i < NC; i++) begin
      cd[i] = '0; occ[i] = 0; seq[i] = 0; delivered[i] = 0; acc_req[i] = 0;
    end
    acc_srv = 0; m_last = NC - 1; m_v = 1'b0; m_id = 0; m_d = '0; err_m = 1'b0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(srv_req_valid === 1'b0, "R8", "srv_req_valid in reset", srv_req_valid, 0);
    check(cli_rsp_valid === '0, "R8", "cli_rsp_valid in reset", cli_rsp_valid, 0);
    check(bad_id_err === 1'b0, "R8", "bad_id_err in reset", bad_id_err, 0);
    @(negedge clk);
    rst = 1'b0;

    req_en = 1;
    repeat (3000) step();

    stall2 = 1;
    repeat (400) step();
    stall2 = 0;
    check(iso_hits > 0, "R6", "other-client accepts while client 2 full", iso_hits, 1);

    inject_bad = 1;
    repeat (1500) step();
    inject_bad = 0;
    check(bad_id_err === 1'b1, "R7", "bad_id_err after bad IDs", bad_id_err, 1);

    req_en = 0; all_ready = 1;
    drained = 0;
    for (int n = 0; n < 3000 && !drained; n++) begin
      step();
      drained = (cli_req_valid == '0) && !m_v && (sq_id.size() == 0);
      for (int i = 0; i < NC; i++)
        if (occ[i] != 0 || exp_q[i].size() != 0) drained = 0;
    end
    check(drained, "R5", "all responses delivered", drained, 1);
    for (int i = 0; i < NC; i++)
      check(delivered[i] > 0 && exp_q[i].size() == 0, "R4",
            $sformatf("client %0d deliveries", i), delivered[i], seq[i]);
    check(bad_id_err === 1'b1, "R7", "bad_id_err held", bad_id_err, 1);

    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(bad_id_err === 1'b0, "R7", "bad_id_err cleared by reset", bad_id_err, 0);
    check(srv_req_valid === 1'b0, "R8", "srv_req_valid after reset", srv_req_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule